// File: doc/BRIEF.md
# LCD Sync Timing Generator with Frame-Synchronous Register Staging

This block produces the horizontal sync, vertical sync, data-enable and pixel-clock-enable strobes for a parallel RGB panel. All timing figures sit in a small bank of write-only registers. Each figure is written as the wanted count less one. A scan line runs through four parts in order: sync pulse, back porch, active pixels, front porch. A frame runs through the same four parts, counted in lines. Everything runs in the system clock domain. The pixel rate comes from a clock enable that can divide the system clock or follow it one to one.

Software loads the registers through a simple write port. The geometry fields, the divider fields and the frame-synchronous run bit are staged. While the raster is running, their new values reach the counters only at the wrap from the last pixel of a frame to the first, which is where the next vertical sync begins. While the raster is stopped, they reach the counters on the same edge as the write. A second run bit, the polarity bits and the interrupt setup act at once.

A frame-level interrupt can follow the start of vertical sync, the end of the active area, or both. It has a master enable and a write-one-to-clear pending flag.

Top module: `lcd_tgen`

## Requirements
- R1: Horizontal fields sit in register address 2: sync width at bits [7:0], back porch at [15:8], front porch at [23:16], each holding pixels minus one. Within a line, hsync is active for the sync width. Data-enable can only become active after sync width plus back porch pixels.
- R2: Vertical fields sit in register address 3, with the same bit positions as R1, counted in lines minus one. Vsync is active for the sync count of whole lines. After the last front-porch line, the raster wraps to line 0, pixel 0, with both syncs active.
- R3: Register address 4 holds active pixels per line minus one at bits [11:0] and active lines minus one at bits [27:16]. Data-enable is active for exactly that many pixels on each of that many lines in every frame.
- R4: In the control register (address 0), bit 2 selects divided pixel timing and bits [15:8] hold the ratio minus one. With bit 2 clear, `pclk_en_o` is high on every running cycle. With bit 2 set, it is high once every ratio cycles. Counters move only on cycles where `pclk_en_o` is high.
- R5: Register address 1 holds output inversion bits: bit 0 for hsync, bit 1 for vsync, bit 2 for data-enable. A write to it changes the output level on the next cycle, even while running.
- R6: While running, writes to addresses 2, 3 and 4, and to control bits [15:8], bit 2 and bit 1, are held back. The frame in progress keeps the old values; the new values apply from the next frame start.
- R7: While stopped, the same staged writes apply at once, so the first frame after starting uses them.
- R8: The raster runs only while control bit 0 (applied at once) and the staged copy of control bit 1 are both set. Clearing bit 0 stops it on the next cycle. Clearing bit 1 lets the current frame finish and then stops.
- R9: While stopped, the counters return to pixel 0, line 0. Each sync and data-enable output sits at its inactive level, which equals its inversion bit. `pclk_en_o` is low.
- R10: Register address 5: bit 0 is the master interrupt enable. Bits [2:1] select the source: bit 1 is the frame start (wrap to line 0), bit 2 is the last pixel of the last active line. With the enable set, a selected event raises `irq_o` on the cycle after the event.
- R11: With the master enable clear, no event sets the pending flag.
- R12: Writing address 6 with bit 0 set clears the pending flag, and `irq_o` drops on the next cycle. Writing it with bit 0 clear has no effect.
- R13: After reset, all registers are zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| pclk_en_o | output | 1 | Pixel clock enable; last system cycle of each pixel |
| hsync_o | output | 1 | Horizontal sync after inversion |
| vsync_o | output | 1 | Vertical sync after inversion |
| de_o | output | 1 | Data-enable after inversion |
| irq_o | output | 1 | Frame interrupt, level |

## Verification
A write takes effect at the rising edge where it is sampled. Immediate fields, including a start or a stop, show at the outputs in the cycle after that edge, because the sync and enable outputs are decoded straight from the counter and register flops. A raster started from idle therefore shows pixel 0 of line 0 in the first cycle after the start write. Each position then lasts `ratio` cycles, so every measured count is the pixel or line count times the ratio. A staged write made during a frame shows one full frame length later. An interrupt event seen in cycle n appears at `irq_o` in cycle n+1. The bench drives and samples at falling edges, counts cycles from the edge where the start write lands, and samples each result in the cycle these rules give.

// File: rtl/lcd_tgen_pkg.sv
// Shared constants and the staged-configuration type for the LCD timing
// generator. Widths assume PORCH_W <= 8, SIZE_W <= 16, DIV_W <= 8 so that
// every field fits its slot in a 32-bit register word.
package lcd_tgen_pkg;
    parameter int PORCH_W = 8;
    parameter int SIZE_W  = 12;
    parameter int DIV_W   = 8;
    parameter int ADDR_W  = 3;
    parameter int DATA_W  = 32;
    parameter int POL_N   = 3;
    parameter int SEL_W   = 2;
    parameter int AXES    = 2;

    localparam int CNT_W        = SIZE_W + 2;
    localparam int FIELD_STRIDE = 8;
    localparam int VACT_LSB     = 16;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_POL     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_HTIME   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_VTIME   = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_SIZE    = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_IRQCFG  = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_IRQSTAT = ADDR_W'(6);

    // bit positions inside register words
    localparam int CTRL_RUN_NOW  = 0;
    localparam int CTRL_RUN_SYNC = 1;
    localparam int CTRL_DIV_ON   = 2;
    localparam int CTRL_DIV_LSB  = 8;
    localparam int POL_HS        = 0;
    localparam int POL_VS        = 1;
    localparam int POL_DE        = 2;
    localparam int IRQ_EN_BIT    = 0;
    localparam int IRQ_SEL_LSB   = 1;
    localparam int IRQ_CLR_BIT   = 0;

    // staged fields: moved to the live copy at frame start or while idle
    typedef struct packed {
        logic               run_sync;
        logic               div_on;
        logic [DIV_W-1:0]   div_m1;
        logic [PORCH_W-1:0] hs_m1;
        logic [PORCH_W-1:0] hbp_m1;
        logic [PORCH_W-1:0] hfp_m1;
        logic [PORCH_W-1:0] vs_m1;
        logic [PORCH_W-1:0] vbp_m1;
        logic [PORCH_W-1:0] vfp_m1;
        logic [SIZE_W-1:0]  hact_m1;
        logic [SIZE_W-1:0]  vact_m1;
    } frame_cfg_t;
endpackage

// File: rtl/lcd_tgen_regs.sv
// Register bank. Decodes the write port into immediate controls and a
// staged copy of the frame configuration. The staged copy, with any write
// of the current cycle merged in, moves to the live copy whenever the
// raster is idle or the raster wraps to its first pixel.
// Assumes one write per cycle; unknown addresses are ignored.
module lcd_tgen_regs
    import lcd_tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              active,
    input  logic              frame_wrap,
    output frame_cfg_t        live_cfg,
    output logic              run_now,
    output logic [POL_N-1:0]  pol,
    output logic              irq_en,
    output logic [SEL_W-1:0]  irq_sel,
    output logic              irq_clr
);
    frame_cfg_t staged_q;
    frame_cfg_t staged_d;
    logic       load_live;
    logic       unused_bits;

    assign unused_bits = ^wr_data;

    // Purpose: merge this cycle's write into the staged configuration.
    always_comb begin
        staged_d = staged_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    staged_d.run_sync = wr_data[CTRL_RUN_SYNC];
                    staged_d.div_on   = wr_data[CTRL_DIV_ON];
                    staged_d.div_m1   = wr_data[CTRL_DIV_LSB +: DIV_W];
                end
                A_HTIME: begin
                    staged_d.hs_m1  = wr_data[0 +: PORCH_W];
                    staged_d.hbp_m1 = wr_data[FIELD_STRIDE +: PORCH_W];
                    staged_d.hfp_m1 = wr_data[2*FIELD_STRIDE +: PORCH_W];
                end
                A_VTIME: begin
                    staged_d.vs_m1  = wr_data[0 +: PORCH_W];
                    staged_d.vbp_m1 = wr_data[FIELD_STRIDE +: PORCH_W];
                    staged_d.vfp_m1 = wr_data[2*FIELD_STRIDE +: PORCH_W];
                end
                A_SIZE: begin
                    staged_d.hact_m1 = wr_data[0 +: SIZE_W];
                    staged_d.vact_m1 = wr_data[VACT_LSB +: SIZE_W];
                end
                default: ;
            endcase
        end
    end

    assign load_live = !active || frame_wrap;

    // Purpose: hold the staged copy and move it live at the allowed points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
            live_cfg <= '0;
        end else begin
            staged_q <= staged_d;
            if (load_live) live_cfg <= staged_d;
        end
    end

    // Purpose: immediate controls that bypass staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_now <= 1'b0;
            pol     <= '0;
            irq_en  <= 1'b0;
            irq_sel <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) run_now <= wr_data[CTRL_RUN_NOW];
            if (wr_addr == A_POL)  pol     <= wr_data[POL_N-1:0];
            if (wr_addr == A_IRQCFG) begin
                irq_en  <= wr_data[IRQ_EN_BIT];
                irq_sel <= wr_data[IRQ_SEL_LSB +: SEL_W];
            end
        end
    end

    // Purpose: one-cycle clear request for the pending interrupt.
    assign irq_clr = wr_en && (wr_addr == A_IRQSTAT) && wr_data[IRQ_CLR_BIT];

    // R6
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !frame_wrap) |=> $stable(live_cfg));

    // R7
    idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && wr_en && wr_addr == A_HTIME)
        |=> live_cfg.hs_m1 == $past(wr_data[PORCH_W-1:0]));
endmodule

// File: rtl/lcd_tgen_pixdiv.sv
// Pixel clock enable. Passes every cycle through when division is off,
// otherwise pulses once per (div_m1 + 1) cycles. Held low and reset to
// phase zero whenever the raster is idle. Assumes div fields change only
// on a pulse or while idle, which the staging guarantees.
module lcd_tgen_pixdiv
    import lcd_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             div_on,
    input  logic [DIV_W-1:0] div_m1,
    output logic             pix_ce
);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [DIV_W-1:0] phase_q;
    logic             tick;

    assign tick   = !div_on || (phase_q == div_m1);
    assign pix_ce = active && tick;

    // Purpose: count system cycles within one pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) phase_q <= '0;
        else if (pix_ce)       phase_q <= '0;
        else                   phase_q <= phase_q + DIV_ONE;
    end

    // R4
    ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce && div_on && div_m1 != '0) |=> (!pix_ce || !div_on || div_m1 == '0));

    // R9
    idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> phase_q == '0);
endmodule

// File: rtl/lcd_tgen_axis.sv
// One raster axis: a position counter that walks sync, back porch,
// active and front porch, then wraps. Used for pixels within a line and
// for lines within a frame. Segment bounds are derived from the live
// minus-one fields every cycle. Assumes PORCH_W <= SIZE_W.
module lcd_tgen_axis
    import lcd_tgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic [PORCH_W-1:0] sync_m1,
    input  logic [PORCH_W-1:0] bp_m1,
    input  logic [SIZE_W-1:0]  act_m1,
    input  logic [PORCH_W-1:0] fp_m1,
    output logic               last,
    output logic               in_sync,
    output logic               in_act,
    output logic               act_last
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] sync_end;
    logic [CNT_W-1:0] act_beg;
    logic [CNT_W-1:0] act_end;
    logic [CNT_W-1:0] total_m1;

    // Purpose: segment boundaries (exclusive ends) from the live fields.
    always_comb begin
        sync_end = CNT_W'(sync_m1) + ONE;
        act_beg  = sync_end + CNT_W'(bp_m1) + ONE;
        act_end  = act_beg + CNT_W'(act_m1) + ONE;
        total_m1 = act_end + CNT_W'(fp_m1);
    end

    assign last     = (pos_q == total_m1);
    assign in_sync  = (pos_q < sync_end);
    assign in_act   = (pos_q >= act_beg) && (pos_q < act_end);
    assign act_last = (pos_q == act_end - ONE);

    // Purpose: advance the position on each step, wrapping after the end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pos_q <= '0;
        else if (step)     pos_q <= last ? '0 : pos_q + ONE;
    end

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= total_m1);

    // R9
    idle_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pos_q == '0);
endmodule

// File: rtl/lcd_tgen_irq.sv
// Frame interrupt. Selected events set a pending flag when the master
// enable is on; a clear request drops it, with a same-cycle set winning.
// The output is the pending flag gated by the master enable.
module lcd_tgen_irq
    import lcd_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_vsync,
    input  logic             ev_porch,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    output logic             irq
);
    logic pending_q;
    logic hit;

    assign hit = (sel[0] && ev_vsync) || (sel[1] && ev_porch);

    // Purpose: track the write-one-to-clear pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)              pending_q <= 1'b0;
        else if (en && hit)      pending_q <= 1'b1;
        else if (clr)            pending_q <= 1'b0;
    end

    assign irq = pending_q && en;

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !pending_q);

    // R11
    set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_q) |-> $past(en && hit));
endmodule

// File: rtl/lcd_tgen.sv
// LCD timing generator top. Joins the register bank, the pixel divider,
// one counter per raster axis and the interrupt. Sync and data-enable
// outputs are decoded from flops only, so they change one edge after a
// pixel enable or a register write. Inactive output level is the
// polarity bit.
module lcd_tgen
    import lcd_tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pclk_en_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              irq_o
);
    frame_cfg_t         live_cfg;
    logic               run_now;
    logic [POL_N-1:0]   pol;
    logic               irq_en;
    logic [SEL_W-1:0]   irq_sel;
    logic               irq_clr;
    logic               active;
    logic               pix_ce;
    logic               frame_wrap;
    logic               ev_porch;

    logic [PORCH_W-1:0] ax_sync_m1 [AXES];
    logic [PORCH_W-1:0] ax_bp_m1   [AXES];
    logic [PORCH_W-1:0] ax_fp_m1   [AXES];
    logic [SIZE_W-1:0]  ax_act_m1  [AXES];
    logic               ax_step    [AXES];
    logic               ax_last    [AXES];
    logic               ax_sync    [AXES];
    logic               ax_act     [AXES];
    logic               ax_act_end [AXES];

    assign active = run_now && live_cfg.run_sync;

    lcd_tgen_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .active     (active),
        .frame_wrap (frame_wrap),
        .live_cfg   (live_cfg),
        .run_now    (run_now),
        .pol        (pol),
        .irq_en     (irq_en),
        .irq_sel    (irq_sel),
        .irq_clr    (irq_clr)
    );

    lcd_tgen_pixdiv div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .div_on (live_cfg.div_on),
        .div_m1 (live_cfg.div_m1),
        .pix_ce (pix_ce)
    );

    assign ax_sync_m1[0] = live_cfg.hs_m1;
    assign ax_bp_m1[0]   = live_cfg.hbp_m1;
    assign ax_fp_m1[0]   = live_cfg.hfp_m1;
    assign ax_act_m1[0]  = live_cfg.hact_m1;
    assign ax_sync_m1[1] = live_cfg.vs_m1;
    assign ax_bp_m1[1]   = live_cfg.vbp_m1;
    assign ax_fp_m1[1]   = live_cfg.vfp_m1;
    assign ax_act_m1[1]  = live_cfg.vact_m1;

    // Axis 0 counts pixels in a line, each further axis steps when the one
    // below it wraps.
    for (genvar g = 0; g < AXES; g++) begin : g_axis
        if (g == 0) begin : g_first
            assign ax_step[g] = pix_ce;
        end else begin : g_next
            assign ax_step[g] = ax_step[g-1] && ax_last[g-1];
        end

        lcd_tgen_axis axis_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (!active),
            .step     (ax_step[g]),
            .sync_m1  (ax_sync_m1[g]),
            .bp_m1    (ax_bp_m1[g]),
            .act_m1   (ax_act_m1[g]),
            .fp_m1    (ax_fp_m1[g]),
            .last     (ax_last[g]),
            .in_sync  (ax_sync[g]),
            .in_act   (ax_act[g]),
            .act_last (ax_act_end[g])
        );
    end

    assign frame_wrap = ax_step[1] && ax_last[1];
    assign ev_porch   = ax_step[1] && ax_act_end[1];

    lcd_tgen_irq irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_vsync (frame_wrap),
        .ev_porch (ev_porch),
        .en       (irq_en),
        .sel      (irq_sel),
        .clr      (irq_clr),
        .irq      (irq_o)
    );

    assign pclk_en_o = pix_ce;
    assign hsync_o   = (active && ax_sync[0]) ^ pol[POL_HS];
    assign vsync_o   = (active && ax_sync[1]) ^ pol[POL_VS];
    assign de_o      = (active && ax_act[0] && ax_act[1]) ^ pol[POL_DE];
endmodule

// File: tb/lcd_tgen_tb_top.sv
module lcd_tgen_tb_top;
    import lcd_tgen_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        int hs; int hbp; int hact; int hfp;
        int vs; int vbp; int vact; int vfp;
        int div_on; int ratio; int pol; int frame;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{2, 3, 8, 2,  1, 2, 4, 1,  0, 1, 0, 120},
        '{1, 1, 4, 1,  2, 1, 3, 2,  1, 3, 7, 168},
        '{3, 2, 5, 4,  1, 1, 2, 1,  1, 1, 2,  70},
        '{1, 1, 1, 1,  1, 1, 1, 1,  0, 1, 5,  16},
        '{4, 4, 16, 4, 2, 2, 6, 2,  1, 2, 4, 672}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        pclk_en_o, hsync_o, vsync_o, de_o, irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_tgen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pclk_en_o (pclk_en_o),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .de_o      (de_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_vec(input vec_t v);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'(v.pol));
        wr(3'd2, 32'(v.hs-1) | (32'(v.hbp-1) << 8) | (32'(v.hfp-1) << 16));
        wr(3'd3, 32'(v.vs-1) | (32'(v.vbp-1) << 8) | (32'(v.vfp-1) << 16));
        wr(3'd4, 32'(v.hact-1) | (32'(v.vact-1) << 16));
    endtask

    task automatic start_vec(input vec_t v);
        wr(3'd0, 32'h3 | (32'(v.div_on) << 2) | (32'(v.ratio-1) << 8));
    endtask

    task automatic wait_vs_rise(output int n);
        logic prev;
        prev = vsync_o;
        n = 0;
        for (int k = 0; k < 2000; k++) begin
            step(1);
            n++;
            if (vsync_o && !prev) break;
            prev = vsync_o;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        vec_t v;
        int htot, vtot, hs_n, vs_n, de_n, ce_n, first_de, vs_last, n, cnt;
        logic hp, vp, dp;

        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        step(4);
        rst_n = 1'b1;
        step(1);

        // R13 reset state
        check("R13 hsync", int'(hsync_o), 0);
        check("R13 vsync", int'(vsync_o), 0);
        check("R13 de", int'(de_o), 0);
        check("R13 pclk_en", int'(pclk_en_o), 0);
        check("R13 irq", int'(irq_o), 0);

        // vector walk: geometry, divider, polarity (R1 R2 R3 R4 R7 R9)
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            hp = v.pol[0]; vp = v.pol[1]; dp = v.pol[2];
            htot = v.hs + v.hbp + v.hact + v.hfp;
            vtot = v.vs + v.vbp + v.vact + v.vfp;
            check("R2 table frame length", v.frame, htot * vtot * v.ratio);
            program_vec(v);
            start_vec(v);
            hs_n = 0; vs_n = 0; de_n = 0; ce_n = 0; first_de = -1; vs_last = 0;
            for (int c = 0; c < v.frame; c++) begin
                hs_n += int'(hsync_o ^ hp);
                vs_n += int'(vsync_o ^ vp);
                de_n += int'(de_o ^ dp);
                ce_n += int'(pclk_en_o);
                if ((de_o ^ dp) && first_de < 0) first_de = c;
                if (c == v.frame - 1) vs_last = int'(vsync_o ^ vp);
                step(1);
            end
            check("R1 hsync cycles", hs_n, v.hs * vtot * v.ratio);
            check("R1 first data-enable cycle", first_de,
                  ((v.vs + v.vbp) * htot + v.hs + v.hbp) * v.ratio);
            check("R2 vsync cycles", vs_n, v.vs * htot * v.ratio);
            check("R2 wrap to line 0", {vs_last[0], vsync_o ^ vp, hsync_o ^ hp}, 3'b011);
            check("R3 data-enable cycles", de_n, v.hact * v.vact * v.ratio);
            check("R4 pixel enables per frame", ce_n, htot * vtot);
            wr(3'd0, 32'd0);
            check("R9 idle levels", {pclk_en_o, de_o, vsync_o, hsync_o}, {1'b0, dp, vp, hp});
        end

        // R4 first enable lands on the last cycle of the first pixel
        v = VECS[1];
        program_vec(v);
        start_vec(v);
        check("R4 no enable in cycle 0 at ratio 3", int'(pclk_en_o), 0);
        step(2);
        check("R4 enable in cycle 2 at ratio 3", int'(pclk_en_o), 1);

        // R5 polarity acts at once while running
        v = VECS[0];
        program_vec(v);
        start_vec(v);
        check("R5 hsync active before invert", int'(hsync_o), 1);
        wr(3'd1, 32'd1);
        check("R5 hsync inverted next cycle", int'(hsync_o), 0);
        wr(3'd1, 32'd0);

        // R6 staged size change waits for the frame end
        program_vec(v);
        start_vec(v);
        wr(3'd4, 32'(4-1) | (32'(4-1) << 16));
        wait_vs_rise(n);
        check("R6 current frame keeps old length", n, 119);
        wait_vs_rise(n);
        check("R6 next frame uses new length", n, 88);

        // R8 clearing the staged run bit finishes the frame
        program_vec(v);
        start_vec(v);
        wr(3'd0, 32'h1);
        cnt = 0;
        for (int k = 0; k < 200; k++) begin
            cnt += int'(pclk_en_o);
            step(1);
        end
        check("R8 frame completes after run_sync clear", cnt, 119);
        check("R8 stopped after frame", {vsync_o, hsync_o, pclk_en_o}, 3'b000);

        // R8 clearing the immediate run bit stops at once
        program_vec(v);
        start_vec(v);
        wr(3'd0, 32'h2);
        check("R8 immediate stop", {hsync_o, pclk_en_o}, 2'b00);

        // R10 vsync-start source
        program_vec(v);
        wr(3'd5, 32'h3);
        start_vec(v);
        step(119);
        check("R10 no irq before frame start", int'(irq_o), 0);
        step(1);
        check("R10 irq after frame start", int'(irq_o), 1);
        wr(3'd6, 32'h1);
        check("R12 irq cleared", int'(irq_o), 0);

        // R10 active-area-end source
        wr(3'd0, 32'd0);
        wr(3'd5, 32'h5);
        start_vec(v);
        step(104);
        check("R10 no irq before active end", int'(irq_o), 0);
        step(1);
        check("R10 irq after active end", int'(irq_o), 1);
        wr(3'd6, 32'h0);
        check("R12 zero write ignored", int'(irq_o), 1);
        wr(3'd6, 32'h1);
        check("R12 one write clears", int'(irq_o), 0);

        // R11 master enable off
        wr(3'd0, 32'd0);
        wr(3'd5, 32'h6);
        start_vec(v);
        cnt = 0;
        for (int k = 0; k < 250; k++) begin
            cnt += int'(irq_o);
            step(1);
        end
        check("R11 no irq with master enable off", cnt, 0);
        wr(3'd5, 32'h7);
        check("R11 nothing pending after enabling", int'(irq_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule